// File: doc/BRIEF.md
# Event Interrupt Controller with Programmable Signalling

This block gathers four peripheral events (data ready, status valid, locality change and command ready) into one interrupt line. Each event arrives as a single-cycle input pulse. The block latches it into a sticky pending register, which software clears by writing ones to it. A pending event drives the line only when its own enable bit is set and the master enable is also set.

The line can signal in four ways, picked by a two-bit field in the control word: active-high level, active-low level, a rising one-cycle pulse or a falling one-cycle pulse. Software reaches the block through a simple word-wide register port with a write strobe and a combinational read. The port holds the control word, the pending word, a small line-number register and a read-only word that lists the supported features.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the control word, the pending word and the line-number register all read zero, and the interrupt output is low.
- R2: The data-ready event (pending bit 0) latches only in a cycle where the data input and the valid input are both high. A data pulse alone leaves bit 0 clear.
- R3: The status-valid, locality and command-ready pulses latch into pending bits 1, 2 and 7. Writing a one to the pending word (byte offset 0x4) clears that bit. If an event and its clear arrive in the same cycle, the event wins and the bit stays set.
- R4: The control word (byte offset 0x0) stores the per-source enables at bits 0, 1, 2 and 7, the signalling field at bits 4:3 and the master enable at bit 31. All other bits read back as zero.
- R5: Events still latch while the master enable is clear, but they leave the output at its idle level.
- R6: In level modes the output follows the enabled-pending condition one cycle after the pending word shows the event. Field 00 drives it high while the condition holds. Field 01 drives it low while the condition holds and high otherwise. A pending source whose enable is clear does not count.
- R7: In field 10 the output idles low and goes high for exactly one cycle when the enabled-pending set goes from empty to non-empty. In field 11 it idles high and goes low for one cycle on the same transition. Further events while the set is already non-empty give no new pulse.
- R8: The line-number register at byte offset 0xC keeps the low four bits written to it. Its upper bits read as zero.
- R9: The feature word at byte offset 0x8 is read-only; writes do not change it. Its bits are: 0 data-ready, 1 status-valid, 2 locality, 3 level-high, 4 level-low, 5 rising, 6 falling, 7 command-ready, 8 fixed burst count. With default parameters it reads 0x000000FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| ev_data | input | 1 | Data-ready condition pulse |
| ev_valid | input | 1 | Status-valid pulse |
| ev_locality | input | 1 | Locality-change pulse |
| ev_ready | input | 1 | Command-ready pulse |
| irq_out | output | 1 | Interrupt line |

## Verification
A source's event pulse can land in the same cycle as a software write that clears the same pending bit. The bench sets the locality and command-ready bits, then in one cycle writes ones to both bits while pulsing locality again. The pending word must then read with the locality bit still set and the command-ready bit gone. The level output must stay asserted through that cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    typedef enum logic [1:0] {
        SIG_LVL_HI = 2'b00,
        SIG_LVL_LO = 2'b01,
        SIG_RISE   = 2'b10,
        SIG_FALL   = 2'b11
    } sig_mode_e;

    localparam int N_SRC    = 4;
    localparam int MASTER_B = 31;
    localparam int MODE_LSB = 3;

    localparam int OFS_CTRL = 'h0;
    localparam int OFS_PEND = 'h4;
    localparam int OFS_FEAT = 'h8;
    localparam int OFS_LINE = 'hC;

    // bit position of source index i in the control and pending words
    function automatic int src_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int LINE_W      = 4,
    parameter bit HAS_LVL_HI  = 1'b1,
    parameter bit HAS_LVL_LO  = 1'b1,
    parameter bit HAS_RISE    = 1'b1,
    parameter bit HAS_FALL    = 1'b1,
    parameter bit FIXED_BURST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_data,
    input  logic              ev_valid,
    input  logic              ev_locality,
    input  logic              ev_ready,
    output logic              master_en,
    output logic [N_SRC-1:0]  src_en,
    output logic [N_SRC-1:0]  pend,
    output sig_mode_e         mode
);

    localparam logic [DATA_W-1:0] FEAT_WORD = DATA_W'({
        FIXED_BURST, 1'b1, HAS_FALL, HAS_RISE, HAS_LVL_LO, HAS_LVL_HI,
        1'b1, 1'b1, 1'b1});

    typedef struct packed {
        logic              master;
        logic [N_SRC-1:0]  en;
        sig_mode_e         mode;
        logic [N_SRC-1:0]  pend;
        logic [LINE_W-1:0] line;
    } regs_t;

    regs_t st_d, st_q;

    logic hit_ctrl, hit_pend, hit_line;
    logic [N_SRC-1:0] ev_set, ev_clr, pend_nx;
    logic unused_wbits;

    assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_pend = (reg_addr == ADDR_W'(OFS_PEND));
    assign hit_line = (reg_addr == ADDR_W'(OFS_LINE));

    // data-ready needs both conditions in the same cycle
    assign ev_set = {ev_ready, ev_locality, ev_valid, ev_data & ev_valid};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam int POS = src_pos(g);
        assign ev_clr[g]  = reg_wr & hit_pend & reg_wdata[POS];
        // a new event beats a clear of the same bit
        assign pend_nx[g] = ev_set[g] | (st_q.pend[g] & ~ev_clr[g]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nx;
        if (reg_wr && hit_ctrl) begin
            st_d.master = reg_wdata[MASTER_B];
            st_d.mode   = sig_mode_e'(reg_wdata[MODE_LSB+1:MODE_LSB]);
            for (int i = 0; i < N_SRC; i++) begin
                st_d.en[i] = reg_wdata[src_pos(i)];
            end
        end
        if (reg_wr && hit_line) begin
            st_d.line = reg_wdata[LINE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{master: 1'b0, en: '0, mode: SIG_LVL_HI, pend: '0, line: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            OFS_CTRL: begin
                reg_rdata[MASTER_B]              = st_q.master;
                reg_rdata[MODE_LSB+1:MODE_LSB]   = st_q.mode;
                for (int i = 0; i < N_SRC; i++) begin
                    reg_rdata[src_pos(i)] = st_q.en[i];
                end
            end
            OFS_PEND: begin
                for (int i = 0; i < N_SRC; i++) begin
                    reg_rdata[src_pos(i)] = st_q.pend[i];
                end
            end
            OFS_FEAT: reg_rdata = FEAT_WORD;
            OFS_LINE: reg_rdata[LINE_W-1:0] = st_q.line;
            default:  reg_rdata = '0;
        endcase
    end

    assign master_en    = st_q.master;
    assign src_en       = st_q.en;
    assign pend         = st_q.pend;
    assign mode         = st_q.mode;
    assign unused_wbits = ^{reg_wdata[DATA_W-2:8], reg_wdata[6:5]};

    // R2: bit 0 only rises after a cycle with data and valid together
    a_r2_data_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend[0]) |-> $past(ev_data && ev_valid));

    // R3: a status-valid pulse always leaves bit 1 set, even against a clear
    a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> st_q.pend[1]);

    // R3: a clear with no concurrent event drops the locality bit
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_pend && reg_wdata[2] && !ev_locality) |=> !st_q.pend[2]);

    // R8: the line number only changes on a write to its offset
    a_r8_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_line) |=> $stable(st_q.line));

endmodule

// File: rtl/evt_irq_shaper.sv
module evt_irq_shaper
    import evt_irq_pkg::*;
#(
    parameter int NSRC = N_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] pend,
    input  sig_mode_e       mode,
    output logic            irq_out
);

    typedef struct packed {
        logic line;
        logic was_active;
    } shp_t;

    shp_t sh_d, sh_q;
    logic active, onset;

    assign active = master_en & |(pend & src_en);
    assign onset  = active & ~sh_q.was_active;

    always_comb begin
        sh_d            = sh_q;
        sh_d.was_active = active;
        case (mode)
            SIG_LVL_HI: sh_d.line = active;
            SIG_LVL_LO: sh_d.line = ~active;
            SIG_RISE:   sh_d.line = onset;
            default:    sh_d.line = ~onset;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{line: 1'b0, was_active: 1'b0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign irq_out = sh_q.line;

    // R5: with the master enable clear, level-high mode keeps the line low
    a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && mode == SIG_LVL_HI) |=> !irq_out);

    // R6: level-high output tracks enabled pending one cycle later
    a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SIG_LVL_HI) |=> (irq_out == $past(master_en && |(pend & src_en))));

    // R7: a rising pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == SIG_RISE && mode == SIG_RISE && irq_out) |=> !irq_out);

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int LINE_W      = 4,
    parameter bit HAS_LVL_HI  = 1'b1,
    parameter bit HAS_LVL_LO  = 1'b1,
    parameter bit HAS_RISE    = 1'b1,
    parameter bit HAS_FALL    = 1'b1,
    parameter bit FIXED_BURST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_data,
    input  logic              ev_valid,
    input  logic              ev_locality,
    input  logic              ev_ready,
    output logic              irq_out
);

    logic             master_en;
    logic [N_SRC-1:0] src_en;
    logic [N_SRC-1:0] pend;
    sig_mode_e        mode;

    evt_irq_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W),
        .HAS_LVL_HI(HAS_LVL_HI), .HAS_LVL_LO(HAS_LVL_LO),
        .HAS_RISE(HAS_RISE), .HAS_FALL(HAS_FALL), .FIXED_BURST(FIXED_BURST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ev_data(ev_data), .ev_valid(ev_valid),
        .ev_locality(ev_locality), .ev_ready(ev_ready),
        .master_en(master_en), .src_en(src_en), .pend(pend), .mode(mode)
    );

    evt_irq_shaper #(.NSRC(N_SRC)) u_shaper (
        .clk(clk), .rst_n(rst_n),
        .master_en(master_en), .src_en(src_en), .pend(pend), .mode(mode),
        .irq_out(irq_out)
    );

endmodule

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_data = 1'b0, ev_valid = 1'b0, ev_locality = 1'b0, ev_ready = 1'b0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ev_data(ev_data), .ev_valid(ev_valid),
        .ev_locality(ev_locality), .ev_ready(ev_ready),
        .irq_out(irq_out)
    );

    // kind: 0 write, 1 read and compare, 2 event pulse {ready,locality,valid,data}
    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [3:0]  ev;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 18;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd1, 4'h8, 32'h0000_00FF, 4'b0000, 8'd9},  // R9 feature word
        '{2'd0, 4'h8, 32'hFFFF_FFFF, 4'b0000, 8'd9},
        '{2'd1, 4'h8, 32'h0000_00FF, 4'b0000, 8'd9},  // R9 write ignored
        '{2'd0, 4'h0, 32'hFFFF_FFFF, 4'b0000, 8'd4},
        '{2'd1, 4'h0, 32'h8000_009F, 4'b0000, 8'd4},  // R4 field layout
        '{2'd0, 4'h0, 32'h0000_0000, 4'b0000, 8'd4},
        '{2'd0, 4'hC, 32'hFFFF_FFFF, 4'b0000, 8'd8},
        '{2'd1, 4'hC, 32'h0000_000F, 4'b0000, 8'd8},  // R8 line number
        '{2'd2, 4'h0, 32'h0,         4'b0001, 8'd2},
        '{2'd1, 4'h4, 32'h0000_0000, 4'b0000, 8'd2},  // R2 data alone
        '{2'd2, 4'h0, 32'h0,         4'b0011, 8'd2},
        '{2'd1, 4'h4, 32'h0000_0003, 4'b0000, 8'd2},  // R2 data with valid
        '{2'd2, 4'h0, 32'h0,         4'b1100, 8'd3},
        '{2'd1, 4'h4, 32'h0000_0087, 4'b0000, 8'd3},  // R3 R5 latch with master off
        '{2'd0, 4'h4, 32'h0000_0005, 4'b0000, 8'd3},
        '{2'd1, 4'h4, 32'h0000_0082, 4'b0000, 8'd3},  // R3 partial clear
        '{2'd0, 4'h4, 32'hFFFF_FFFF, 4'b0000, 8'd3},
        '{2'd1, 4'h4, 32'h0000_0000, 4'b0000, 8'd3}   // R3 full clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] ev);
        @(negedge clk);
        {ev_ready, ev_locality, ev_valid, ev_data} = ev;
        @(negedge clk);
        {ev_ready, ev_locality, ev_valid, ev_data} = '0;
    endtask

    task automatic irq_next(input logic exp, input string req);
        @(negedge clk);
        check(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) begin
            string tag;
            tag = $sformatf("R%0d step%0d", STEPS[i].req, i);
            case (STEPS[i].kind)
                2'd0:    bus_wr(STEPS[i].addr, STEPS[i].data);
                2'd1:    bus_rd(STEPS[i].addr, STEPS[i].data, tag);
                default: pulse(STEPS[i].ev);
            endcase
        end

        // R1: reset state after the table left registers non-zero
        bus_wr(4'h0, 32'h8000_009F);
        pulse(4'b1000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 irq", {31'd0, irq_out}, 32'd0);
        bus_rd(4'h0, 32'h0, "R1 ctrl");
        bus_rd(4'h4, 32'h0, "R1 pend");
        bus_rd(4'hC, 32'h0, "R1 line");

        // R5: master off, all sources enabled, level-high
        bus_wr(4'h0, 32'h0000_0087);
        pulse(4'b1000);
        irq_next(1'b0, "R5 gated");
        irq_next(1'b0, "R5 gated hold");
        bus_rd(4'h4, 32'h0000_0080, "R5 still latched");

        // R6: level-high then level-low
        bus_wr(4'h0, 32'h8000_0087);
        irq_next(1'b1, "R6 level-high asserted");
        bus_wr(4'h4, 32'h0000_0080);
        irq_next(1'b0, "R6 level-high released");
        bus_wr(4'h0, 32'h8000_008F);
        irq_next(1'b1, "R6 level-low idle");
        pulse(4'b1000);
        irq_next(1'b0, "R6 level-low asserted");
        bus_wr(4'h4, 32'h0000_0080);
        irq_next(1'b1, "R6 level-low released");
        // R6: pending source with its enable clear does not count
        bus_wr(4'h0, 32'h8000_0001);
        pulse(4'b0100);
        irq_next(1'b0, "R6 masked source");
        bus_wr(4'h4, 32'hFFFF_FFFF);

        // R7: rising pulse
        bus_wr(4'h0, 32'h8000_0097);
        irq_next(1'b0, "R7 rise idle");
        pulse(4'b0100);
        irq_next(1'b1, "R7 rise pulse");
        irq_next(1'b0, "R7 rise one cycle");
        pulse(4'b1000);
        irq_next(1'b0, "R7 no pulse while pending");
        irq_next(1'b0, "R7 no pulse while pending 2");
        bus_wr(4'h4, 32'h0000_0084);
        pulse(4'b0100);
        irq_next(1'b1, "R7 rise pulse after clear");
        bus_wr(4'h4, 32'hFFFF_FFFF);

        // R7: falling pulse
        bus_wr(4'h0, 32'h8000_009F);
        irq_next(1'b1, "R7 fall idle");
        pulse(4'b1000);
        irq_next(1'b0, "R7 fall pulse");
        irq_next(1'b1, "R7 fall one cycle");
        bus_wr(4'h4, 32'hFFFF_FFFF);

        // R3: event and clear of the same bit in one cycle
        bus_wr(4'h0, 32'h8000_0087);
        pulse(4'b1100);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h0000_0084; ev_locality = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; ev_locality = 1'b0;
        #1;
        check("R3 event beats clear", reg_rdata, 32'h0000_0004);
        check("R6 level held through clash", {31'd0, irq_out}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule